// File: doc/BRIEF.md
# Command/Response Buffer Register Front End

This block is the memory-mapped control face of a security coprocessor that exchanges work through a shared command/response buffer. Host software reaches it over a simple little-endian register bus. Accesses may be 1, 2, 3 or 4 bytes wide. The block tracks three things. The first is whether software owns the interface (locality ownership). The second is whether the coprocessor is parked idle or made ready. The third is whether a command is outstanding. It turns accepted start and cancel requests into single-cycle pulses toward a backend. It takes back a completion strobe that carries an error flag.

The 64 KiB window is split into sixteen 4 KiB locality windows. Address bits [15:12] give the locality of a write. Reads decode only the offset inside a window. Identification and buffer-descriptor registers are constants set by parameters. The buffer RAM itself lives outside this block.

Three small state machines make up the block:
- Ownership machine: states `LOC_FREE` and `LOC_HELD`. The transition grant goes from `LOC_FREE` to `LOC_HELD`; the transition release goes back.
- Power machine: states `PWR_IDLE` and `PWR_READY`. The transition wake goes from `PWR_IDLE` to `PWR_READY`; the transition park goes back.
- Command machine: states `CMD_IDLE` and `CMD_BUSY`. The transition launch goes from `CMD_IDLE` to `CMD_BUSY`; the transition finish goes back on completion.

Top module: `cbr_regfront`

## Requirements
- R1: After reset the reads return these values. Offset 0x000 returns 0x80, with register-valid at bit 7, when the established input is 1. Offset 0x00C returns 0. Offset 0x044 returns 0x2, with idle at bit 1 and fatal at bit 0. Offset 0x04C returns 0. Offset 0x030 returns 0x00025811. Offsets 0x058 and 0x064 return BUF_SIZE. Offsets 0x05C and 0x068 return BUF_BASE.
- R2: A read returns the addressed 32-bit word shifted right by 8 times address bits [1:0].
- R3: Bit 0 of a read at offset 0x000 equals the inverse of the `be_established` input.
- R4: Writing the value 1 to offset 0x008 claims ownership. After it, offset 0x000 shows bit 1 set and offset 0x00C shows bit 0 set. Writing 2 releases ownership and clears both bits. Any other value, including 8, has no effect.
- R5: Writing 1 to offset 0x040 clears the idle bit (bit 1 of 0x044). Writing 2 sets it. Other values are ignored.
- R6: Writing 1 to offset 0x04C from locality 0 starts a command. This needs ownership held and no command outstanding. `be_start` is then high for exactly the one cycle after the write, and bit 0 of 0x04C reads 1.
- R7: A start write does nothing when ownership is not held, when it comes from a locality other than 0, or while a command is outstanding.
- R8: Writing 1 to offset 0x048 pulses `be_cancel` for one cycle, but only while a command is outstanding. Otherwise, or with any other value, the write does nothing.
- R9: `be_done` clears bit 0 of 0x04C. If `be_error` is 1 at the same time, the fatal bit (bit 0 of 0x044) is set and stays set until reset.
- R10: Reads of unmapped offsets return 0. Writes to read-only or unmapped offsets, and writes whose address bits [1:0] are not 0, change nothing.
- R11: A written value is masked to the access size before it is compared. `bus_size` 0 means 1 byte, 1 means 2 bytes, 2 means 3 bytes and 3 means 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [15:12] give the locality of a write |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 2 | Access width minus one, in bytes |
| bus_wdata | input | 32 | Write data, least significant byte first |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| be_established | input | 1 | Backend established flag |
| be_done | input | 1 | Backend completion strobe |
| be_error | input | 1 | Completion failed, valid with be_done |
| be_start | output | 1 | One-cycle command start request |
| be_cancel | output | 1 | One-cycle command cancel request |

## Verification
The assertions assume that the backend raises `be_done` only while a command is outstanding. They also assume that `be_done` and `be_error` are single-cycle strobes and that `bus_wr` lasts one cycle per access. The bench's completion task therefore always follows an accepted start. Every write is a one-cycle strobe driven on the falling edge. Reads are sampled combinationally at a falling edge, so the write and read timing never overlap at the active edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int WORD_IDX_W = 10;

    localparam logic [WORD_IDX_W-1:0] WI_LOC_STATE = 10'd0;
    localparam logic [WORD_IDX_W-1:0] WI_LOC_CTRL  = 10'd2;
    localparam logic [WORD_IDX_W-1:0] WI_LOC_STS   = 10'd3;
    localparam logic [WORD_IDX_W-1:0] WI_IFACE_ID  = 10'd12;
    localparam logic [WORD_IDX_W-1:0] WI_CTRL_REQ  = 10'd16;
    localparam logic [WORD_IDX_W-1:0] WI_CTRL_STS  = 10'd17;
    localparam logic [WORD_IDX_W-1:0] WI_CANCEL    = 10'd18;
    localparam logic [WORD_IDX_W-1:0] WI_START     = 10'd19;
    localparam logic [WORD_IDX_W-1:0] WI_CMD_SIZE  = 10'd22;
    localparam logic [WORD_IDX_W-1:0] WI_CMD_ADDR  = 10'd23;
    localparam logic [WORD_IDX_W-1:0] WI_RSP_SIZE  = 10'd25;
    localparam logic [WORD_IDX_W-1:0] WI_RSP_ADDR  = 10'd26;

    localparam logic [31:0] OWN_CLAIM   = 32'd1;
    localparam logic [31:0] OWN_RELEASE = 32'd2;
    localparam logic [31:0] PWR_WAKE    = 32'd1;
    localparam logic [31:0] PWR_PARK    = 32'd2;
    localparam logic [31:0] GO_CODE     = 32'd1;

    localparam logic [7:0] NO_OWNER = 8'hFF;

    typedef enum logic { LOC_FREE, LOC_HELD } loc_state_e;
    typedef enum logic { PWR_IDLE, PWR_READY } pwr_state_e;
    typedef enum logic { CMD_IDLE, CMD_BUSY } cmd_state_e;
endpackage

// File: rtl/cbr_loc_fsm.sv
module cbr_loc_fsm
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic [31:0] wr_val,
    output logic        held
);
    loc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOC_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOC_FREE: if (wr_ctrl && wr_val == OWN_CLAIM)   state_d = LOC_HELD;
            LOC_HELD: if (wr_ctrl && wr_val == OWN_RELEASE) state_d = LOC_FREE;
            default:  state_d = LOC_FREE;
        endcase
    end

    assign held = (state_q == LOC_HELD);

    assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_val == OWN_RELEASE) |=> !held);
    assert_claim_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_val == OWN_CLAIM) |=> held);
endmodule

// File: rtl/cbr_pwr_fsm.sv
module cbr_pwr_fsm
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic [31:0] wr_val,
    output logic        idle
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_IDLE:  if (wr_req && wr_val == PWR_WAKE) state_d = PWR_READY;
            PWR_READY: if (wr_req && wr_val == PWR_PARK) state_d = PWR_IDLE;
            default:   state_d = PWR_IDLE;
        endcase
    end

    assign idle = (state_q == PWR_IDLE);

    assert_wake_clears_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_val == PWR_WAKE) |=> !idle);
    assert_other_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req) |=> $stable(idle));
endmodule

// File: rtl/cbr_cmd_fsm.sv
module cbr_cmd_fsm
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_start,
    input  logic        wr_cancel,
    input  logic [31:0] wr_val,
    input  logic        owner_match,
    input  logic        done,
    input  logic        err,
    output logic        busy,
    output logic        fatal,
    output logic        start_pulse,
    output logic        cancel_pulse
);
    cmd_state_e state_q, state_d;
    logic launch, abort, fatal_q;

    always_comb begin
        launch = 1'b0;
        abort  = 1'b0;
        unique case (state_q)
            CMD_IDLE: launch = wr_start && wr_val == GO_CODE && owner_match;
            CMD_BUSY: abort  = wr_cancel && wr_val == GO_CODE;
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (launch) state_d = CMD_BUSY;
            CMD_BUSY: if (done)   state_d = CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse  <= 1'b0;
            cancel_pulse <= 1'b0;
            fatal_q      <= 1'b0;
        end else begin
            start_pulse  <= launch;
            cancel_pulse <= abort;
            if (done && err) fatal_q <= 1'b1;
        end
    end

    assign busy  = (state_q == CMD_BUSY);
    assign fatal = fatal_q;

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);
    assert_cancel_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_pulse |-> $past(busy));
    assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |=> !busy);
    assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

// File: rtl/cbr_rd_mux.sv
module cbr_rd_mux
    import cbr_pkg::*;
#(
    parameter logic [31:0] BUF_BASE = 32'hFED4_0080,
    parameter logic [31:0] BUF_SIZE = 32'h0000_0F80,
    parameter logic [31:0] IFACE_ID = 32'h0002_5811
) (
    input  logic [11:0] rd_off,
    input  logic        established,
    input  logic        held,
    input  logic        idle,
    input  logic        fatal,
    input  logic        busy,
    output logic [31:0] rdata
);
    logic [31:0] word;

    always_comb begin
        word = 32'd0;
        unique case (rd_off[11:2])
            WI_LOC_STATE: word = {24'd0, 1'b1, 5'd0, held, ~established};
            WI_LOC_STS:   word = {31'd0, held};
            WI_IFACE_ID:  word = IFACE_ID;
            WI_CTRL_STS:  word = {30'd0, idle, fatal};
            WI_START:     word = {31'd0, busy};
            WI_CMD_SIZE:  word = BUF_SIZE;
            WI_CMD_ADDR:  word = BUF_BASE;
            WI_RSP_SIZE:  word = BUF_SIZE;
            WI_RSP_ADDR:  word = BUF_BASE;
            default:      word = 32'd0;
        endcase
    end

    assign rdata = word >> {rd_off[1:0], 3'b000};
endmodule

// File: rtl/cbr_regfront.sv
module cbr_regfront
    import cbr_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [31:0] BUF_BASE = 32'hFED4_0080,
    parameter logic [31:0] BUF_SIZE = 32'h0000_0F80,
    parameter logic [31:0] IFACE_ID = 32'h0002_5811
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              be_established,
    input  logic              be_done,
    input  logic              be_error,
    output logic              be_start,
    output logic              be_cancel
);
    localparam int LOC_W = ADDR_W - 12;

    logic [31:0]      wr_val;
    logic [LOC_W-1:0] wr_loc;
    logic [7:0]       active_owner;
    logic             wr_ok, owner_match;
    logic             held, idle, busy, fatal;

    always_comb begin
        unique case (bus_size)
            2'd0:    wr_val = {24'd0, bus_wdata[7:0]};
            2'd1:    wr_val = {16'd0, bus_wdata[15:0]};
            2'd2:    wr_val = {8'd0, bus_wdata[23:0]};
            default: wr_val = bus_wdata;
        endcase
    end

    assign wr_ok        = bus_wr && (bus_addr[1:0] == 2'b00);
    assign wr_loc       = bus_addr[ADDR_W-1:12];
    assign active_owner = held ? 8'h00 : NO_OWNER;
    assign owner_match  = (8'(wr_loc) == active_owner);

    cbr_loc_fsm loc_i (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ok && bus_addr[11:2] == WI_LOC_CTRL),
        .wr_val(wr_val), .held(held)
    );

    cbr_pwr_fsm pwr_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_ok && bus_addr[11:2] == WI_CTRL_REQ),
        .wr_val(wr_val), .idle(idle)
    );

    cbr_cmd_fsm cmd_i (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_ok && bus_addr[11:2] == WI_START),
        .wr_cancel(wr_ok && bus_addr[11:2] == WI_CANCEL),
        .wr_val(wr_val), .owner_match(owner_match),
        .done(be_done), .err(be_error),
        .busy(busy), .fatal(fatal),
        .start_pulse(be_start), .cancel_pulse(be_cancel)
    );

    cbr_rd_mux #(.BUF_BASE(BUF_BASE), .BUF_SIZE(BUF_SIZE), .IFACE_ID(IFACE_ID)) rd_i (
        .rd_off(bus_addr[11:0]), .established(be_established),
        .held(held), .idle(idle), .fatal(fatal), .busy(busy),
        .rdata(bus_rdata)
    );

    assert_lane_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] == 2'd3) |-> (bus_rdata[31:8] == 24'd0));
    assert_est_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:0] == 12'h000) |-> (bus_rdata[0] == !be_established));
    assert_no_owner_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !busy) |=> !be_start);
endmodule

// File: tb/cbr_regfront_tb_top.sv
module cbr_regfront_tb_top;
    localparam logic [31:0] BASE = 32'hFED4_0080;
    localparam logic [31:0] SIZE = 32'h0000_0F80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'd0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd3;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        be_established = 1'b1;
    logic        be_done = 1'b0;
    logic        be_error = 1'b0;
    logic        be_start, be_cancel;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cbr_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .be_established(be_established), .be_done(be_done), .be_error(be_error),
        .be_start(be_start), .be_cancel(be_cancel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic complete(input logic e);
        @(negedge clk);
        be_done = 1'b1; be_error = e;
        @(negedge clk);
        be_done = 1'b0; be_error = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 loc_state", 16'h0000, 32'h80);
        rd_chk("R1 loc_sts", 16'h000C, 32'h0);
        rd_chk("R1 ctrl_sts", 16'h0044, 32'h2);
        rd_chk("R1 start", 16'h004C, 32'h0);
        rd_chk("R1 iface", 16'h0030, 32'h0002_5811);
        rd_chk("R1 cmd_size", 16'h0058, SIZE);
        rd_chk("R1 cmd_addr", 16'h005C, BASE);
        rd_chk("R1 rsp_size", 16'h0064, SIZE);
        rd_chk("R1 rsp_addr", 16'h0068, BASE);
    endtask

    task automatic t_lanes;
        rd_chk("R2 lane1", 16'h0031, 32'h0000_0258);
        rd_chk("R2 lane2", 16'h0032, 32'h0000_0002);
        rd_chk("R2 lane3", 16'h0033, 32'h0000_0000);
        rd_chk("R2 lane1 base", 16'h005D, BASE >> 8);
    endtask

    task automatic t_established;
        be_established = 1'b0;
        rd_chk("R3 est low", 16'h0000, 32'h81);
        be_established = 1'b1;
        rd_chk("R3 est high", 16'h0000, 32'h80);
    endtask

    task automatic t_ownership;
        wr(16'h0008, 2'd3, 32'd1);
        rd_chk("R4 claim state", 16'h0000, 32'h82);
        rd_chk("R4 claim sts", 16'h000C, 32'h1);
        wr(16'h0008, 2'd3, 32'd8);
        rd_chk("R4 est-reset ignored", 16'h0000, 32'h82);
        wr(16'h0008, 2'd3, 32'd3);
        rd_chk("R4 mixed ignored", 16'h000C, 32'h1);
        wr(16'h0008, 2'd3, 32'd2);
        rd_chk("R4 release state", 16'h0000, 32'h80);
        rd_chk("R4 release sts", 16'h000C, 32'h0);
    endtask

    task automatic t_power;
        wr(16'h0040, 2'd3, 32'd1);
        rd_chk("R5 wake", 16'h0044, 32'h0);
        wr(16'h0040, 2'd3, 32'd3);
        rd_chk("R5 other ignored", 16'h0044, 32'h0);
        wr(16'h0040, 2'd3, 32'd2);
        rd_chk("R5 park", 16'h0044, 32'h2);
    endtask

    task automatic t_command;
        wr(16'h004C, 2'd3, 32'd1);
        chk("R7 no owner pulse", {31'd0, be_start}, 32'd0);
        rd_chk("R7 no owner start", 16'h004C, 32'h0);
        wr(16'h0008, 2'd3, 32'd1);
        wr(16'h104C, 2'd3, 32'd1);
        chk("R7 wrong locality", {31'd0, be_start}, 32'd0);
        wr(16'h0048, 2'd3, 32'd1);
        chk("R8 cancel idle", {31'd0, be_cancel}, 32'd0);
        wr(16'h004C, 2'd3, 32'd1);
        chk("R6 start pulse", {31'd0, be_start}, 32'd1);
        rd_chk("R6 start bit", 16'h004C, 32'h1);
        @(negedge clk);
        chk("R6 pulse ends", {31'd0, be_start}, 32'd0);
        wr(16'h004C, 2'd3, 32'd1);
        chk("R7 busy restart", {31'd0, be_start}, 32'd0);
        wr(16'h0048, 2'd3, 32'd2);
        chk("R8 cancel bad value", {31'd0, be_cancel}, 32'd0);
        wr(16'h0048, 2'd3, 32'd1);
        chk("R8 cancel pulse", {31'd0, be_cancel}, 32'd1);
        @(negedge clk);
        chk("R8 cancel ends", {31'd0, be_cancel}, 32'd0);
        complete(1'b0);
        rd_chk("R9 done clears", 16'h004C, 32'h0);
        rd_chk("R9 no fatal", 16'h0044, 32'h2);
        wr(16'h004C, 2'd3, 32'd1);
        chk("R6 second start", {31'd0, be_start}, 32'd1);
        complete(1'b1);
        rd_chk("R9 err clears start", 16'h004C, 32'h0);
        rd_chk("R9 fatal set", 16'h0044, 32'h3);
        repeat (3) @(negedge clk);
        rd_chk("R9 fatal sticky", 16'h0044, 32'h3);
    endtask

    task automatic t_unmapped;
        rd_chk("R10 unmapped 0x010", 16'h0010, 32'h0);
        rd_chk("R10 unmapped 0x100", 16'h0100, 32'h0);
        wr(16'h0030, 2'd3, 32'd0);
        rd_chk("R10 ro iface", 16'h0030, 32'h0002_5811);
        wr(16'h0058, 2'd3, 32'd0);
        rd_chk("R10 ro size", 16'h0058, SIZE);
        wr(16'h004D, 2'd0, 32'd1);
        chk("R10 unaligned start", {31'd0, be_start}, 32'd0);
        rd_chk("R10 unaligned no bit", 16'h004C, 32'h0);
    endtask

    task automatic t_sizing;
        wr(16'h0040, 2'd3, 32'h0000_0101);
        rd_chk("R11 full width no match", 16'h0044, 32'h3);
        wr(16'h0040, 2'd0, 32'h0000_0101);
        rd_chk("R11 byte masked match", 16'h0044, 32'h1);
        wr(16'h0040, 2'd1, 32'hFF00_0002);
        rd_chk("R11 halfword masked", 16'h0044, 32'h3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_established();
        t_ownership();
        t_power();
        t_command();
        t_unmapped();
        t_sizing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule